// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives already split into fields: a class code, a sign, a signed unbiased exponent, a normalised mantissa whose most significant bit is the explicit leading one, and a sticky bit that stands for any precision lost before the operand reached the block. The conversion always truncates toward zero. No rounding mode is consulted.

The mantissa is aligned so that its integer part lands in the result word. Any fraction bits that drop out, together with the incoming sticky bit, raise the inexact flag. Operands that cannot be represented saturate and raise the invalid flag, and the invalid flag replaces inexact. Such operands are infinities, NaNs, exponents of 32 or more, and magnitudes outside the signed range. The block has one register stage. A pulse on `valid_i` yields a result, with both flags, on `valid_o` one clock later.

Top module: `f2i_conv`

## Requirements
- R1: Class code 0 (zero) gives result 0 with inexact and invalid both clear, whatever the other fields and the sticky bit hold.
- R2: For class code 1 (number) with exponent e in 0..31, the magnitude is floor(mant * 2^(e - (MANT_W-1))), truncated toward zero.
- R3: For an in-range number, inexact is set exactly when a nonzero mantissa bit is discarded by the alignment or `sticky_i` is 1.
- R4: A number with a negative exponent gives result 0, with inexact set when the mantissa or `sticky_i` is nonzero.
- R5: A number with exponent 32 or more is an overflow.
- R6: A truncated magnitude of at least 2^31 + sign is an overflow, so -2^31 is accepted for negative operands and +2^31 is rejected.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are all treated as overflow.
- R8: On overflow the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1, invalid is 1 and inexact is 0.
- R9: A valid result for a negative operand is the two's-complement negation of the truncated magnitude.
- R10: `valid_o` is `valid_i` delayed by one clock. Result and flags update only in a cycle after `valid_i` was high and otherwise hold their values.
- R11: Inexact and invalid are never both set on a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand valid |
| cls_i | input | 3 | Operand class code |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Signed unbiased exponent |
| mant_i | input | MANT_W | Normalised mantissa, explicit leading one at the top bit |
| sticky_i | input | 1 | Precision already lost upstream |
| valid_o | output | 1 | Result valid |
| res_o | output | 32 | Two's-complement integer result |
| inexact_o | output | 1 | Fraction discarded by truncation |
| invalid_o | output | 1 | Operand out of integer range or not a number |

## Verification
The assertions check on every cycle the properties that do not depend on arithmetic. These are the one-cycle valid delay, that outputs hold between operands, that the two flags exclude each other, that saturation values go with invalid, and that zero, non-number classes and large exponents map to their fixed outcomes. Only the bench's sweeps can show that alignment is correct. These sweeps cover exponents from well below zero to past 32, both signs, several mantissa patterns, and the sticky bit on and off. They also cover the exact integer value, inexact detection from individual discarded bits, and the asymmetric boundary at 2^31.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } f2i_cls_e;

  typedef struct packed {
    logic [31:0] res;
    logic        nx;
    logic        nv;
  } f2i_out_t;
endpackage

// File: rtl/f2i_align.sv
// Right-aligns the integer part of the mantissa; reports discarded bits.
module f2i_align #(
  parameter int MANT_W = 64,
  parameter int INT_W  = 32,
  localparam int EL_W  = $clog2(INT_W),
  localparam int SH_W  = $clog2(MANT_W + 1)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EL_W-1:0]   exp_lo_i,   // exponent, known to be in 0..INT_W-1
  input  logic              below_one_i, // exponent negative
  output logic [INT_W-1:0]  mag_o,
  output logic              lost_o
);
  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] lost_mask;

  always_comb begin
    sh        = SH_W'(MANT_W - 1) - SH_W'(exp_lo_i);
    shifted   = mant_i >> sh;
    lost_mask = ~({MANT_W{1'b1}} << sh);
    if (below_one_i) begin
      mag_o  = '0;
      lost_o = |mant_i;
    end else begin
      mag_o  = INT_W'(shifted);
      lost_o = |(mant_i & lost_mask);
    end
  end
endmodule

// File: rtl/f2i_range.sv
// Range check, saturation and sign application.
module f2i_range #(
  parameter int INT_W = 32
) (
  input  logic             is_zero_i,
  input  logic             in_range_i, // number class with exponent below INT_W
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             sticky_i,
  output logic [INT_W-1:0] res_o,
  output logic             nx_o,
  output logic             nv_o
);
  localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};

  logic too_big;
  logic ovf;

  always_comb begin
    // -2^(INT_W-1) is representable, +2^(INT_W-1) is not
    too_big = (mag_i > MIN_NEG) || (mag_i == MIN_NEG && !sign_i);
    ovf     = !is_zero_i && (!in_range_i || too_big);
    if (is_zero_i) begin
      res_o = '0;
      nx_o  = 1'b0;
      nv_o  = 1'b0;
    end else if (ovf) begin
      res_o = sign_i ? MIN_NEG : MAX_POS;
      nx_o  = 1'b0;
      nv_o  = 1'b1;
    end else begin
      res_o = sign_i ? (~mag_i + 1'b1) : mag_i;
      nx_o  = lost_i | sticky_i;
      nv_o  = 1'b0;
    end
  end

  // R11: invalid overrides inexact
  always_comb a_r11_flag_excl_comb: assert (!(nx_o && nv_o));
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [2:0]              cls_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic                    valid_o,
  output logic [31:0]             res_o,
  output logic                    inexact_o,
  output logic                    invalid_o
);
  localparam int INT_W = 32;
  localparam int EL_W  = $clog2(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic             is_zero, is_num, below_one, exp_big, in_range;
  logic [INT_W-1:0] mag;
  logic             lost;
  f2i_out_t         nxt, q;

  always_comb begin
    is_zero   = (cls_i == CLS_ZERO);
    is_num    = (cls_i == CLS_NUM);
    below_one = exp_i < 0;
    exp_big   = exp_i >= EXP_LIM;
    in_range  = is_num && !exp_big;
  end

  f2i_align #(.MANT_W(MANT_W), .INT_W(INT_W)) u_align (
    .mant_i      (mant_i),
    .exp_lo_i    (exp_i[EL_W-1:0]),
    .below_one_i (below_one),
    .mag_o       (mag),
    .lost_o      (lost)
  );

  f2i_range #(.INT_W(INT_W)) u_range (
    .is_zero_i  (is_zero),
    .in_range_i (in_range),
    .sign_i     (sign_i),
    .mag_i      (mag),
    .lost_i     (lost),
    .sticky_i   (sticky_i),
    .res_o      (nxt.res),
    .nx_o       (nxt.nx),
    .nv_o       (nxt.nv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q       <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q <= nxt;
    end
  end

  assign res_o     = q.res;
  assign inexact_o = q.nx;
  assign invalid_o = q.nv;

  a_r10_valid_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_valid_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(inexact_o) && $stable(invalid_o)));
  a_r11_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(inexact_o && invalid_o));
  a_r8_sat_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |-> (res_o == 32'h7FFF_FFFF || res_o == 32'h8000_0000));
  a_r1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == CLS_ZERO) |=> (res_o == '0 && !inexact_o && !invalid_o));
  a_r5_big_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == CLS_NUM && exp_i >= EXP_LIM) |=> invalid_o);
  a_r7_non_number: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i != CLS_ZERO && cls_i != CLS_NUM) |=> (invalid_o && !inexact_o));
endmodule

// File: tb/f2i_conv_tb.sv
`timescale 1ns/1ps
module f2i_conv_tb;
  localparam int MANT_W = 40;
  localparam int EXP_W  = 12;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    valid_i = 1'b0;
  logic [2:0]              cls_i = '0;
  logic                    sign_i = 1'b0;
  logic signed [EXP_W-1:0] exp_i = '0;
  logic [MANT_W-1:0]       mant_i = '0;
  logic                    sticky_i = 1'b0;
  logic                    valid_o, inexact_o, invalid_o;
  logic [31:0]             res_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  f2i_conv #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cls_i(cls_i),
    .sign_i(sign_i), .exp_i(exp_i), .mant_i(mant_i), .sticky_i(sticky_i),
    .valid_o(valid_o), .res_o(res_o), .inexact_o(inexact_o), .invalid_o(invalid_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp_v);
    end
  endtask

  // Apply one operand, compare registered outputs one clock later.
  task automatic run(input logic [2:0] c, input logic s, input int e,
                     input logic [MANT_W-1:0] m, input logic st);
    logic [127:0] fx;
    logic [63:0]  ip;
    logic [31:0]  eres;
    logic         enx, env, ovf;
    string        rq;
    @(negedge clk);
    cls_i = c; sign_i = s; exp_i = EXP_W'(e); mant_i = m; sticky_i = st; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    ovf = 1'b0; enx = 1'b0; eres = '0;
    if (c == 3'd0) begin
      rq = "R1";
    end else if (c != 3'd1) begin
      rq = "R7"; ovf = 1'b1;
    end else if (e >= 32) begin
      rq = "R5"; ovf = 1'b1;
    end else begin
      fx = 128'(m) << (64 - (MANT_W - 1) + e);
      ip = fx[127:64];
      enx = (fx[63:0] != 0) || st;
      if (ip >= 64'h8000_0000 + 64'(s)) begin
        rq = "R6"; ovf = 1'b1;
      end else begin
        eres = s ? 32'(-ip) : ip[31:0];
        rq = (e < 0) ? "R4" : (s ? "R9" : "R2");
      end
    end
    if (ovf) begin
      eres = s ? 32'h8000_0000 : 32'h7FFF_FFFF; enx = 1'b0; env = 1'b1;
      chk({rq, "/R8 result"}, res_o, eres);
    end else begin
      env = 1'b0;
      chk({rq, " result"}, res_o, eres);
    end
    chk("R3 inexact", 32'(inexact_o), 32'(enx));
    chk("R11 invalid", 32'(invalid_o), 32'(env));
    chk("R10 valid_o", 32'(valid_o), 32'd1);
  endtask

  initial begin
    logic [MANT_W-1:0] pats [5];
    pats[0] = 40'h80_0000_0000;
    pats[1] = 40'hFF_FFFF_FFFF;
    pats[2] = 40'hC0_0000_0001;
    pats[3] = 40'hAA_AAAA_AAAA;
    pats[4] = 40'h80_0000_0100;
    #1;
    chk("R10 reset valid_o", 32'(valid_o), 32'd0);
    chk("R10 reset res_o", res_o, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3 R4 R5 R6 R9: sweep of exponents, signs, patterns, sticky
    for (int e = -20; e <= 40; e++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 5; p++)
          for (int st = 0; st < 2; st++)
            run(3'd1, s[0], e, pats[p], st[0]);
    // R1 zero class ignores other fields; R7 all non-number codes
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        run(c[2:0], s[0], 5, 40'hFF_FFFF_FFFF, 1'b1);
    // R6 boundary: exactly 2^31, and 2^31-1
    run(3'd1, 1'b1, 31, 40'h80_0000_0000, 1'b0);
    run(3'd1, 1'b0, 31, 40'h80_0000_0000, 1'b0);
    run(3'd1, 1'b0, 30, 40'hFF_FFFF_FE00, 1'b0);
    // R10: hold while valid_i low with changed inputs
    @(negedge clk);
    cls_i = 3'd2; sign_i = 1'b1;
    begin
      logic [31:0] held;
      held = res_o;
      @(negedge clk);
      chk("R10 hold res_o", res_o, held);
      chk("R10 valid_o low", 32'(valid_o), 32'd0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule